// File: doc/BRIEF.md
# Charge Current Modulator

This block produces the one-bit charge-enable signal that switches the charging current of a battery charger on and off. A charge controller tells it which phase is active: idle, pending, fast, top-off or trickle. In fast charge it acts as a hysteretic switch-mode regulator. Two comparator flags report whether the sense-resistor voltage is below the low threshold or above the high threshold, and the output latches between them. When an external current regulator is fitted, the output instead stays high for the whole fast phase.

In top-off it emits fixed pulses with a one-to-seven on/off ratio. In trickle and pending it emits one fixed-width pulse per period, and that period comes from two three-state timer-select inputs. All timing counts a 1 µs tick strobe, so the pulse and period lengths are in microseconds by default. An over-voltage report from the controller drops the output on the next clock edge and takes priority over every other input.

Top module: `chg_mod_drive`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released with `mode_req` = 0, `chg_en` is 0.
- R2: The charge phase code `mode_req` is 0 idle, 1 pending, 2 fast, 3 top-off, 4 trickle. Codes 0, 5, 6 and 7 drive `chg_en` to 0 on the next edge.
- R3: In fast (code 2) with `ext_reg_sel` = 0, `chg_en` goes to 1 on an edge where `sense_below_lo` = 1 and goes to 0 where `sense_above_hi` = 1. If both flags are 1, the result is 0. With neither flag set, it keeps its level. That level starts at 0 on entry to fast.
- R4: In fast with `ext_reg_sel` = 1, `chg_en` is 1 on every edge without over-voltage.
- R5: In top-off with top-off enabled, `chg_en` is 1 for PULSE_TICKS ticks, then 0 for TOPOFF_GAP_TICKS ticks, repeating. The defaults are 260 and 1820.
- R6: Each timer-select input is a 2-bit code: 00 low, 01 float, 10 high. Let L = 0, F = 1, H = 2 and write the pair as (a,b). The trickle period in units of TRICKLE_UNIT_TICKS (default 15000) is 16 for (F,L), 8 for (H,L) or (H,F), 4 for (L,F) or (L,H), 2 for (F,F) or (F,H), and 1 for (H,H). Top-off is enabled only for (H,F), (L,H), (F,H) and (H,H).
- R7: In trickle (code 4) and pending (code 1), `chg_en` is 1 for PULSE_TICKS ticks at the start of every trickle period and 0 for the rest of it.
- R8: With both selects at low, `chg_en` is 0 in pending, top-off and trickle. Top-off in a selection without top-off also gives 0.
- R9: `over_volt` = 1 forces `chg_en` to 0 on that edge and clears the fast-charge hysteresis level.
- R10: On an edge where `mode_req` differs from its previous value, the pulse position restarts at zero. The first pulse of the new phase therefore starts on that edge and lasts a full PULSE_TICKS.
- R11: The unused select code 11 is treated as low.
- R12: Pulse timing advances only on edges where `tick_us` = 1. Edges without a tick leave the pulse position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | 1 µs timing strobe, one clock wide |
| mode_req | input | 3 | Requested charge phase code |
| sense_below_lo | input | 1 | Sense voltage below low threshold |
| sense_above_hi | input | 1 | Sense voltage above high threshold |
| ext_reg_sel | input | 1 | External current regulator fitted |
| tm_sel_a | input | 2 | First timer-select three-state code |
| tm_sel_b | input | 2 | Second timer-select three-state code |
| over_volt | input | 1 | Controller reports cell above maximum voltage |
| chg_en | output | 1 | Registered charge-enable output |

## Verification
An over-voltage report can arrive on the same edge as a phase change. That edge both restarts the pulse position and would otherwise begin a full first pulse. The stimulus raises `over_volt` on one entry edge in four and at random within phases. A cycle-by-cycle bench model expects the output low on that edge. From then on it expects the pulse pattern counted from the restart, so any design that lets the kill skip or shift the restart shows up as a mismatch on the following pulses.

// File: rtl/chg_mod_pkg.sv
package chg_mod_pkg;

  typedef enum logic [2:0] {
    CM_OFF     = 3'd0,
    CM_PEND    = 3'd1,
    CM_FAST    = 3'd2,
    CM_TOPOFF  = 3'd3,
    CM_TRICKLE = 3'd4
  } chg_mode_e;

  // Three-state pin levels after folding the unused code onto low.
  localparam logic [1:0] TL_LOW   = 2'd0;
  localparam logic [1:0] TL_FLOAT = 2'd1;
  localparam logic [1:0] TL_HIGH  = 2'd2;

  typedef struct packed {
    logic       trickle_en;
    logic       topoff_en;
    logic [2:0] shift;     // trickle period = unit << shift
  } pulse_cfg_t;

  function automatic logic [1:0] tri_level(input logic [1:0] code);
    return (code == 2'b11) ? TL_LOW : code;
  endfunction

endpackage

// File: rtl/chg_tm_decode.sv
module chg_tm_decode
  import chg_mod_pkg::*;
(
  input  logic [1:0] tm_a,
  input  logic [1:0] tm_b,
  output pulse_cfg_t cfg
);

  logic [1:0] lvl_a;
  logic [1:0] lvl_b;
  logic [3:0] sel_idx;

  always_comb begin
    lvl_a   = tri_level(tm_a);
    lvl_b   = tri_level(tm_b);
    sel_idx = {2'b00, lvl_a} + 4'd3 * {2'b00, lvl_b};
    cfg     = '0;
    case (sel_idx)
      4'd1: cfg = '{trickle_en: 1'b1, topoff_en: 1'b0, shift: 3'd4};
      4'd2: cfg = '{trickle_en: 1'b1, topoff_en: 1'b0, shift: 3'd3};
      4'd3: cfg = '{trickle_en: 1'b1, topoff_en: 1'b0, shift: 3'd2};
      4'd4: cfg = '{trickle_en: 1'b1, topoff_en: 1'b0, shift: 3'd1};
      4'd5: cfg = '{trickle_en: 1'b1, topoff_en: 1'b1, shift: 3'd3};
      4'd6: cfg = '{trickle_en: 1'b1, topoff_en: 1'b1, shift: 3'd2};
      4'd7: cfg = '{trickle_en: 1'b1, topoff_en: 1'b1, shift: 3'd1};
      4'd8: cfg = '{trickle_en: 1'b1, topoff_en: 1'b1, shift: 3'd0};
      default: cfg = '0;
    endcase
  end

endmodule

// File: rtl/chg_hyst_latch.sv
module chg_hyst_latch (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic clear,
  input  logic below_lo,
  input  logic above_hi,
  output logic level_d,
  output logic level_q
);

  always_comb begin
    if (clear || !active)  level_d = 1'b0;
    else if (above_hi)     level_d = 1'b0;
    else if (below_lo)     level_d = 1'b1;
    else                   level_d = level_q;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_d;
  end

endmodule

// File: rtl/chg_pulse_timer.sv
module chg_pulse_timer #(
  parameter int CW    = 18,
  parameter int PULSE = 260
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          on
);

  localparam logic [CW-1:0] PULSE_C = CW'(PULSE);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;

  always_comb begin
    pos = restart ? '0 : cnt_q;
    on  = (pos < PULSE_C);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= (pos >= limit - ONE_C) ? '0 : pos + ONE_C;
    else
      cnt_q <= pos;
  end

endmodule

// File: rtl/chg_mod_drive.sv
module chg_mod_drive
  import chg_mod_pkg::*;
#(
  parameter int PULSE_TICKS        = 260,
  parameter int TOPOFF_GAP_TICKS   = 1820,
  parameter int TRICKLE_UNIT_TICKS = 15000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic [2:0] mode_req,
  input  logic       sense_below_lo,
  input  logic       sense_above_hi,
  input  logic       ext_reg_sel,
  input  logic [1:0] tm_sel_a,
  input  logic [1:0] tm_sel_b,
  input  logic       over_volt,
  output logic       chg_en
);

  localparam int TRK_MAX   = TRICKLE_UNIT_TICKS * 16;
  localparam int TOP_PER   = PULSE_TICKS + TOPOFF_GAP_TICKS;
  localparam int MAX_PER   = (TRK_MAX > TOP_PER) ? TRK_MAX : TOP_PER;
  localparam int CW        = $clog2(MAX_PER + 1);
  localparam logic [CW-1:0] TOP_LIM  = CW'(TOP_PER);
  localparam logic [CW-1:0] UNIT_LIM = CW'(TRICKLE_UNIT_TICKS);

  pulse_cfg_t    cfg;
  logic [2:0]    mode_q;
  logic          restart;
  logic [CW-1:0] limit;
  logic          pulse_on;
  logic          hyst_d;
  logic          hyst_q;
  logic          is_fast;
  logic          en_d;
  logic          en_q;

  chg_tm_decode u_dec (
    .tm_a (tm_sel_a),
    .tm_b (tm_sel_b),
    .cfg  (cfg)
  );

  assign restart = (mode_req != mode_q);
  assign is_fast = (mode_req == CM_FAST);

  always_comb begin
    case (mode_req)
      CM_TOPOFF:          limit = TOP_LIM;
      CM_PEND, CM_TRICKLE: limit = UNIT_LIM << cfg.shift;
      default:            limit = '0;
    endcase
  end

  chg_pulse_timer #(
    .CW    (CW),
    .PULSE (PULSE_TICKS)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_us),
    .restart (restart),
    .limit   (limit),
    .on      (pulse_on)
  );

  chg_hyst_latch u_hyst (
    .clk      (clk),
    .rst      (rst),
    .active   (is_fast),
    .clear    (over_volt),
    .below_lo (sense_below_lo),
    .above_hi (sense_above_hi),
    .level_d  (hyst_d),
    .level_q  (hyst_q)
  );

  always_comb begin
    en_d = 1'b0;
    if (!over_volt) begin
      case (mode_req)
        CM_FAST:             en_d = ext_reg_sel | hyst_d;
        CM_TOPOFF:           en_d = cfg.topoff_en & pulse_on;
        CM_PEND, CM_TRICKLE: en_d = cfg.trickle_en & pulse_on;
        default:             en_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CM_OFF;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_req;
      en_q   <= en_d;
    end
  end

  assign chg_en = en_q;

  // hyst_q feeds the hold path only through hyst_d; tie it into nothing else.
  logic unused_hyst;
  assign unused_hyst = hyst_q;

endmodule

// File: rtl/chg_mod_drive_chk.sv
module chg_mod_drive_chk
  import chg_mod_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick_us,
  input logic [2:0] mode_req,
  input logic       sense_below_lo,
  input logic       sense_above_hi,
  input logic       ext_reg_sel,
  input logic [1:0] tm_sel_a,
  input logic [1:0] tm_sel_b,
  input logic       over_volt,
  input logic       chg_en
);

  logic [2:0] mode_seen;
  logic       prev_hyst_ok;
  logic [1:0] la, lb;
  logic       trk_ok, top_ok, pulse_mode, idle_mode, fast_hyst;

  always_comb begin
    la         = tri_level(tm_sel_a);
    lb         = tri_level(tm_sel_b);
    trk_ok     = !(la == TL_LOW && lb == TL_LOW);
    top_ok     = (lb == TL_HIGH) || (lb == TL_FLOAT && la == TL_HIGH);
    pulse_mode = (mode_req == CM_PEND) || (mode_req == CM_TOPOFF) ||
                 (mode_req == CM_TRICKLE);
    idle_mode  = (mode_req == CM_OFF) || (mode_req > CM_TRICKLE);
    fast_hyst  = (mode_req == CM_FAST) && !ext_reg_sel && !over_volt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_seen    <= CM_OFF;
      prev_hyst_ok <= 1'b0;
    end else begin
      mode_seen    <= mode_req;
      prev_hyst_ok <= fast_hyst;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !chg_en);

  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    idle_mode |=> !chg_en);

  p_hyst_set_r3: assert property (@(posedge clk) disable iff (rst)
    (fast_hyst && sense_below_lo && !sense_above_hi) |=> chg_en);

  p_hyst_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_req == CM_FAST && !ext_reg_sel && sense_above_hi) |=> !chg_en);

  p_hyst_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fast_hyst && !sense_below_lo && !sense_above_hi && prev_hyst_ok)
    |=> chg_en == $past(chg_en));

  p_ext_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_req == CM_FAST && ext_reg_sel && !over_volt) |=> chg_en);

  p_disabled_low_r8: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && !trk_ok) |=> !chg_en);

  p_ovp_kill_r9: assert property (@(posedge clk) disable iff (rst)
    over_volt |=> !chg_en);

  p_first_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode_req != mode_seen) && !over_volt &&
     (((mode_req == CM_PEND || mode_req == CM_TRICKLE) && trk_ok) ||
      (mode_req == CM_TOPOFF && top_ok))) |=> chg_en);

  p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && mode_req == mode_seen && !tick_us && !over_volt)
    ##1 (mode_req == $past(mode_req) && !over_volt &&
         tm_sel_a == $past(tm_sel_a) && tm_sel_b == $past(tm_sel_b))
    |=> chg_en == $past(chg_en));

endmodule

bind chg_mod_drive chg_mod_drive_chk u_chk (.*);

// File: tb/chg_mod_drive_bench.sv
`timescale 1ns/1ps
module chg_mod_drive_bench;

  localparam int P = 3;
  localparam int G = 21;
  localparam int U = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b0;
  logic [2:0] mode_req = 3'd0;
  logic       sense_below_lo = 1'b0;
  logic       sense_above_hi = 1'b0;
  logic       ext_reg_sel = 1'b0;
  logic [1:0] tm_sel_a = 2'b00;
  logic [1:0] tm_sel_b = 2'b00;
  logic       over_volt = 1'b0;
  logic       chg_en;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  reported = 1'b0;

  always #2.5 clk = ~clk;

  chg_mod_drive #(
    .PULSE_TICKS        (P),
    .TOPOFF_GAP_TICKS   (G),
    .TRICKLE_UNIT_TICKS (U)
  ) u_chg_mod_drive (
    .clk            (clk),
    .rst            (rst),
    .tick_us        (tick_us),
    .mode_req       (mode_req),
    .sense_below_lo (sense_below_lo),
    .sense_above_hi (sense_above_hi),
    .ext_reg_sel    (ext_reg_sel),
    .tm_sel_a       (tm_sel_a),
    .tm_sel_b       (tm_sel_b),
    .over_volt      (over_volt),
    .chg_en         (chg_en)
  );

  // R6, R11: level of a select code, 11 folded to low
  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b11) ? 0 : int'(c);
  endfunction

  // R6: trickle period multiplier, 0 when pulses are disabled (R8)
  function automatic int trk_mult(input logic [1:0] a, input logic [1:0] b);
    int idx;
    idx = lvl(a) + 3 * lvl(b);
    case (idx)
      1: return 16;
      2: return 8;
      3: return 4;
      4: return 2;
      5: return 8;
      6: return 4;
      7: return 2;
      8: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit top_allowed(input logic [1:0] a, input logic [1:0] b);
    return (lvl(b) == 2) || (lvl(b) == 1 && lvl(a) == 2);
  endfunction

  // Reference model, advanced on each rising edge from the applied inputs.
  int         m_pos = 0;
  bit         m_lvl = 1'b0;
  logic [2:0] m_prev = 3'd0;
  bit         m_exp = 1'b0;
  string      m_tag = "R1";

  always @(posedge clk) begin
    int p, lim, mult;
    bit on, nl, chg;
    if (rst) begin
      m_pos = 0; m_lvl = 1'b0; m_prev = 3'd0; m_exp = 1'b0; m_tag = "R1";
    end else begin
      chg  = (mode_req != m_prev);
      p    = chg ? 0 : m_pos;
      mult = trk_mult(tm_sel_a, tm_sel_b);
      if (mode_req == 3'd3)                        lim = P + G;
      else if (mode_req == 3'd1 || mode_req == 3'd4) lim = mult * U;
      else                                         lim = 0;
      on = (p < P);
      if (over_volt || mode_req != 3'd2) nl = 1'b0;
      else if (sense_above_hi)           nl = 1'b0;
      else if (sense_below_lo)           nl = 1'b1;
      else                               nl = m_lvl;
      m_lvl = nl;
      case (mode_req)
        3'd2: begin m_exp = ext_reg_sel | nl; m_tag = ext_reg_sel ? "R4" : "R3"; end
        3'd3: begin m_exp = top_allowed(tm_sel_a, tm_sel_b) & on; m_tag = "R5"; end
        3'd1, 3'd4: begin m_exp = (mult != 0) & on; m_tag = "R6,R7"; end
        default: begin m_exp = 1'b0; m_tag = "R2"; end
      endcase
      if ((mode_req == 3'd1 || mode_req == 3'd3 || mode_req == 3'd4)) begin
        if (tm_sel_a == 2'b11 || tm_sel_b == 2'b11) m_tag = "R11";
        else if (mult == 0 || (mode_req == 3'd3 && !top_allowed(tm_sel_a, tm_sel_b))) m_tag = "R8";
        else if (chg) m_tag = "R10";
        else if (!tick_us) m_tag = "R12";
      end
      if (over_volt) begin m_exp = 1'b0; m_tag = "R9"; end
      if (tick_us) m_pos = (lim > 0 && p >= lim - 1) ? 0 : p + 1;
      else         m_pos = p;
      m_prev = mode_req;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (!reported) begin
      n_vec++;
      if (chg_en !== m_exp) begin
        n_bad++;
        $display("FAIL %s at %0t: chg_en=%b expected=%b mode=%0d", m_tag, $time,
                 chg_en, m_exp, mode_req);
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
  endtask

  task automatic step(input logic [2:0] m, input bit lo, input bit hi,
                      input bit ov, input bit tk);
    @(negedge clk);
    mode_req = m; sense_below_lo = lo; sense_above_hi = hi;
    over_volt = ov; tick_us = tk;
  endtask

  initial begin
    void'($urandom(32'h0C4A_12E5));
    // R1: reset holds the output low
    repeat (4) @(negedge clk);
    @(negedge clk) rst = 1'b0;

    // Directed R3 sequence: enter fast between thresholds, set, hold, clear, both flags
    tm_sel_a = 2'b01; tm_sel_b = 2'b00;
    step(3'd2, 0, 0, 0, 1);
    step(3'd2, 1, 0, 0, 1);
    step(3'd2, 0, 0, 0, 1);
    step(3'd2, 0, 0, 0, 1);
    step(3'd2, 0, 1, 0, 1);
    step(3'd2, 1, 0, 0, 1);
    step(3'd2, 1, 1, 0, 1);
    // R9: kill while set, then hold stays low
    step(3'd2, 1, 0, 0, 1);
    step(3'd2, 0, 0, 1, 1);
    step(3'd2, 0, 0, 0, 1);
    // R4: external gate
    ext_reg_sel = 1'b1;
    step(3'd2, 0, 1, 0, 1);
    step(3'd2, 0, 0, 0, 1);
    ext_reg_sel = 1'b0;
    // R10 + R9 on the same edge: trickle entry killed, then pattern from restart
    step(3'd4, 0, 0, 1, 1);
    repeat (40) step(3'd4, 0, 0, 0, 1);
    // R12: trickle with ticks gated
    step(3'd0, 0, 0, 0, 1);
    repeat (60) step(3'd4, 0, 0, 0, ($urandom % 3) == 0);
    // R11: code 11 as low, top-off with (L,H)
    tm_sel_a = 2'b11; tm_sel_b = 2'b10;
    step(3'd0, 0, 0, 0, 1);
    repeat (60) step(3'd3, 0, 0, 0, 1);

    // Constrained random segments
    for (int s = 0; s < 220; s++) begin
      logic [2:0] m;
      int len;
      step(3'd0, 0, 0, 0, 1);
      m = 3'($urandom % 8);
      if (($urandom % 2) == 0) m = 3'(1 + $urandom % 4);
      tm_sel_a = 2'($urandom % 4);
      tm_sel_b = 2'($urandom % 4);
      ext_reg_sel = (($urandom % 3) == 0);
      len = 40 + int'($urandom % 260);
      for (int c = 0; c < len; c++) begin
        int r;
        bit lo, hi, ov, tk;
        r  = int'($urandom % 16);
        lo = (r < 5) || (r == 15);
        hi = (r >= 5 && r < 10) || (r == 15);
        ov = (c == 0) ? (($urandom % 4) == 0) : (($urandom % 97) == 0);
        tk = (($urandom % 8) != 0);
        step(m, lo, hi, ov, tk);
      end
    end
    step(3'd0, 0, 0, 0, 1);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
      $finish;
    end
  end

endmodule